// File: doc/BRIEF.md
# Storage PHY Control Register Bank with Per-Bit Write Masks

This block holds the control settings of a storage-interface PHY in a small bank of word-addressed registers and reports the PHY's calibration and DLL state through one read-only status word. Every write carries its own lane mask: the upper half-word of the write data selects which of the lower sixteen bits are changed. Software can therefore flip the DLL enable or the drive-strength code without first reading the register, and two agents that own different fields of one register cannot overwrite each other's settings.

The bus is a plain single-cycle port: byte address, write strobe, write data and a combinational read data. The stored fields drive the PHY directly: power-up, DLL enable, drive strength, output tap delay enable and select, and DLL frequency range. All seven control words also leave the block as one flat vector. The two PHY status inputs are captured in a register every cycle. A flag shows whether the current drive-strength code is one of the five defined settings.

Top module: `phy_ctrl_regbank`

## Requirements
- R1: While reset is active and after it is released, every control bit reads as zero: the PHY power-up, DLL enable, tap delay enable and all multi-bit fields are 0.
- R2: On a write to control word k, lower bit x (0..15) takes write-data bit x only when write-data bit x+16 is 1. With that mask bit 0, bit x keeps its old value. The new value is visible on the next clock.
- R3: Control word k (0..6) sits at byte offset 4*k. A read returns the stored sixteen bits in data bits 15:0, and data bits 31:16 read as zero.
- R4: The status word at byte offset 0x20 reads calibration-done in bit 6 and DLL-ready in bit 5, each active high, with all other bits zero. The values read are those the inputs had at the previous rising clock edge.
- R5: Writes to offset 0x20, 0x1C or any offset from 0x24 to 0x3C change no control bit. Reads of 0x1C and of 0x24 to 0x3C return zero.
- R6: The word at 0x18 drives power-up from bit 0, DLL enable from bit 1 and the 3-bit drive code from bits 6:4. The word at 0x00 drives tap delay enable from bit 11, the 4-bit tap select from bits 10:7 and the 2-bit frequency range from bits 13:12.
- R7: drive_legal is 1 exactly when the drive code is 0 (50 ohm), 1 (33 ohm), 2 (66 ohm), 3 (100 ohm) or 4 (40 ohm), and 0 for codes 5 to 7.
- R8: With the write strobe low, address and write-data activity changes no control bit.
- R9: Address bits 1:0 are ignored. Any byte address inside a word selects that word for both read and write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 6 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data: [31:16] lane mask, [15:0] value |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cal_done_in | input | 1 | PHY calibration finished |
| dll_ready_in | input | 1 | PHY DLL locked |
| pwr_up | output | 1 | PHY analog power-up (0 = powered down) |
| dll_en | output | 1 | DLL enable |
| drive_sel | output | 3 | Drive strength code |
| drive_legal | output | 1 | Drive code is a defined setting |
| otap_en | output | 1 | Output tap delay enable |
| otap_sel | output | 4 | Output tap delay select |
| freq_sel | output | 2 | DLL frequency range |
| ctrl_flat | output | 112 | All seven control words, word k at bits 16k+15:16k |

## Verification
On every cycle the assertions check the masked update: bits outside the mask hold and bits inside it take the written value. They also check that an unstrobed cycle leaves a word stable, that no word is selected by a write to the status offset, that upper read bits stay zero, that unmapped reads return zero, that the status bits follow the previous-cycle inputs, and that power-up follows a masked write to 0x18. Only the bench's sweeps can show that the whole address map decodes correctly, including the ignored low address bits. The same holds for the field placement on the named outputs, the legal-code flag over all eight codes, and the return to zero after a reset in mid-run.

// File: rtl/phyrb_pkg.sv
package phyrb_pkg;
  localparam int WORD_W     = 32;
  localparam int HALF_W     = WORD_W / 2;
  localparam int NUM_CTRL   = 7;
  localparam int ADDR_W     = 6;
  localparam int IDX_W      = ADDR_W - 2;
  localparam int STATUS_IDX = 8;
  localparam int CAL_BIT    = 6;
  localparam int DLL_BIT    = 5;
  localparam int PWR_IDX    = 6;
  localparam int TAP_IDX    = 0;

  typedef enum logic [2:0] {
    DRV_50  = 3'd0,
    DRV_33  = 3'd1,
    DRV_66  = 3'd2,
    DRV_100 = 3'd3,
    DRV_40  = 3'd4
  } drive_code_e;
endpackage

// File: rtl/phyrb_rst_sync.sv
module phyrb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/phyrb_decode.sv
module phyrb_decode
  import phyrb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic [NUM_CTRL-1:0] wr_sel,
  output logic              rd_ctrl,
  output logic              rd_status,
  output logic [IDX_W-1:0]  idx
);
  logic unused_lo;

  assign idx       = addr[ADDR_W-1:2];
  assign unused_lo = ^addr[1:0];

  always_comb begin
    for (int i = 0; i < NUM_CTRL; i++) begin
      wr_sel[i] = wr && (idx == IDX_W'(i));
    end
    rd_ctrl   = (int'(idx) < NUM_CTRL);
    rd_status = (idx == IDX_W'(STATUS_IDX));
  end

  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel)); // R5
  AST_NO_WR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !rd_ctrl) |-> (wr_sel == '0)); // R5
endmodule

// File: rtl/phyrb_masked_reg.sv
module phyrb_masked_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = (q & ~mask) | (d & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (we) begin
      q <= q_nxt;
    end
  end

  AST_KEEP_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (((q ^ $past(q)) & ~$past(mask)) == '0)); // R2
  AST_TAKE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (((q ^ $past(d)) & $past(mask)) == '0)); // R2
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q)); // R8
endmodule

// File: rtl/phy_ctrl_regbank.sv
module phy_ctrl_regbank
  import phyrb_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_wr,
  input  logic [WORD_W-1:0]          bus_wdata,
  output logic [WORD_W-1:0]          bus_rdata,
  input  logic                       cal_done_in,
  input  logic                       dll_ready_in,
  output logic                       pwr_up,
  output logic                       dll_en,
  output logic [2:0]                 drive_sel,
  output logic                       drive_legal,
  output logic                       otap_en,
  output logic [3:0]                 otap_sel,
  output logic [1:0]                 freq_sel,
  output logic [NUM_CTRL*HALF_W-1:0] ctrl_flat
);
  logic                rst_i_n;
  logic [NUM_CTRL-1:0] wr_sel;
  logic                rd_ctrl;
  logic                rd_status;
  logic [IDX_W-1:0]    idx;
  logic                cal_q, dll_q;
  logic [HALF_W-1:0]   word_pwr, word_tap;

  phyrb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  phyrb_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .addr      (bus_addr),
    .wr        (bus_wr),
    .wr_sel    (wr_sel),
    .rd_ctrl   (rd_ctrl),
    .rd_status (rd_status),
    .idx       (idx)
  );

  generate
    for (genvar k = 0; k < NUM_CTRL; k++) begin : g_word
      phyrb_masked_reg #(.W(HALF_W)) u_word (
        .clk   (clk),
        .rst_n (rst_i_n),
        .we    (wr_sel[k]),
        .mask  (bus_wdata[WORD_W-1:HALF_W]),
        .d     (bus_wdata[HALF_W-1:0]),
        .q     (ctrl_flat[k*HALF_W +: HALF_W])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cal_q <= 1'b0;
      dll_q <= 1'b0;
    end else begin
      cal_q <= cal_done_in;
      dll_q <= dll_ready_in;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_ctrl) begin
      for (int k = 0; k < NUM_CTRL; k++) begin
        if (idx == IDX_W'(k)) begin
          bus_rdata[HALF_W-1:0] = ctrl_flat[k*HALF_W +: HALF_W];
        end
      end
    end else if (rd_status) begin
      bus_rdata[CAL_BIT] = cal_q;
      bus_rdata[DLL_BIT] = dll_q;
    end
  end

  assign word_pwr    = ctrl_flat[PWR_IDX*HALF_W +: HALF_W];
  assign word_tap    = ctrl_flat[TAP_IDX*HALF_W +: HALF_W];
  assign pwr_up      = word_pwr[0];
  assign dll_en      = word_pwr[1];
  assign drive_sel   = word_pwr[6:4];
  assign otap_sel    = word_tap[10:7];
  assign otap_en     = word_tap[11];
  assign freq_sel    = word_tap[13:12];
  assign drive_legal = (drive_sel <= DRV_40);

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_i_n)
    rd_ctrl |-> (bus_rdata[WORD_W-1:HALF_W] == '0)); // R3
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!rd_ctrl && !rd_status) |-> (bus_rdata == '0)); // R5
  AST_STATUS_CAL: assert property (@(posedge clk) disable iff (!rst_i_n)
    rd_status |-> (bus_rdata[CAL_BIT] == $past(cal_done_in))); // R4
  AST_STATUS_DLL: assert property (@(posedge clk) disable iff (!rst_i_n)
    rd_status |-> (bus_rdata[DLL_BIT] == $past(dll_ready_in))); // R4
  AST_PWR_WRITE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_wr && idx == IDX_W'(PWR_IDX) && bus_wdata[HALF_W]) |=>
      (pwr_up == $past(bus_wdata[0]))); // R6
endmodule

// File: tb/tb_phy_ctrl_regbank.sv
module tb_phy_ctrl_regbank;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 7;

  logic        clk, rst_n;
  logic [5:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        cal_done_in, dll_ready_in;
  logic        pwr_up, dll_en, drive_legal, otap_en;
  logic [2:0]  drive_sel;
  logic [3:0]  otap_sel;
  logic [1:0]  freq_sel;
  logic [NW*16-1:0] ctrl_flat;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;
  logic [15:0] model [NW];

  phy_ctrl_regbank dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cal_done_in(cal_done_in), .dll_ready_in(dll_ready_in),
    .pwr_up(pwr_up), .dll_en(dll_en), .drive_sel(drive_sel),
    .drive_legal(drive_legal), .otap_en(otap_en), .otap_sel(otap_sel),
    .freq_sel(freq_sel), .ctrl_flat(ctrl_flat)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input int idx, input bit c, input bit d);
    if (idx < NW) return {16'h0, model[idx]};
    if (idx == 8) return (32'(c) << 6) | (32'(d) << 5);
    return 32'h0;
  endfunction

  task automatic wr(input logic [5:0] a, input logic [31:0] data);
    @(negedge clk);
    bus_addr = a; bus_wdata = data; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (int'(a[5:2]) < NW)
      model[a[5:2]] = (model[a[5:2]] & ~data[31:16]) | (data[15:0] & data[31:16]);
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      bus_addr = 6'(i * 4 + (i % 4));
      #1;
      chk(bus_rdata == exp_read(i, cal_done_in, dll_ready_in), req,
          bus_rdata, exp_read(i, cal_done_in, dll_ready_in));
    end
    chk({pwr_up, dll_en, drive_sel} == {model[6][0], model[6][1], model[6][6:4]},
        "R6 pwr word fields", {27'h0, pwr_up, dll_en, drive_sel},
        {27'h0, model[6][0], model[6][1], model[6][6:4]});
    chk({otap_en, otap_sel, freq_sel} == {model[0][11], model[0][10:7], model[0][13:12]},
        "R6 tap word fields", {25'h0, otap_en, otap_sel, freq_sel},
        {25'h0, model[0][11], model[0][10:7], model[0][13:12]});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int k = 0; k < NW; k++) model[k] = 16'h0;
    chk(pwr_up == 1'b0 && dll_en == 1'b0, "R1 in reset", {30'h0, pwr_up, dll_en}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<100000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    cal_done_in = 1'b0; dll_ready_in = 1'b0;
    for (int k = 0; k < NW; k++) model[k] = 16'h0;
    do_reset();
    read_all("R1 reset state");
    chk(ctrl_flat == '0, "R1 flat zero", 32'(ctrl_flat[31:0]), 32'h0);

    // R2 R3 R5 R9 sweep over every word, with varied masks and low address bits
    for (int idx = 0; idx < 16; idx++) begin
      for (int p = 0; p < 6; p++) begin
        logic [15:0] m, v;
        m = 16'(p * 16'h3A5B + idx * 16'h0F0F);
        if (p == 0) m = 16'hFFFF;
        if (p == 5) m = 16'h0000;
        v = ~m ^ 16'(idx * p * 16'h1357 + 16'hA5C3);
        wr(6'(idx * 4 + (p % 4)), {m, v});
        read_all("R2/R3/R5/R9 sweep");
      end
    end

    // R8 strobe low
    @(negedge clk);
    bus_addr = 6'h18; bus_wdata = 32'hFFFF_5A5A; bus_wr = 1'b0;
    repeat (2) @(negedge clk);
    read_all("R8 no strobe");

    // R4 status combinations
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      cal_done_in = s[1]; dll_ready_in = s[0];
      bus_addr = 6'h20;
      @(negedge clk);
      #1;
      chk(bus_rdata == ((32'(s[1]) << 6) | (32'(s[0]) << 5)), "R4 status",
          bus_rdata, (32'(s[1]) << 6) | (32'(s[0]) << 5));
    end
    wr(6'h20, 32'hFFFF_FFFF);
    read_all("R5 status write ignored");

    // R6 field placement
    wr(6'h18, 32'h0077_0043);
    chk(pwr_up == 1'b1 && dll_en == 1'b1 && drive_sel == 3'd4, "R6 pwr fields",
        {27'h0, pwr_up, dll_en, drive_sel}, 32'h1C);
    wr(6'h00, 32'h3F80_2D00);
    chk(otap_en == 1'b1 && otap_sel == 4'hA && freq_sel == 2'd2, "R6 tap fields",
        {25'h0, otap_en, otap_sel, freq_sel}, {25'h0, 1'b1, 4'hA, 2'd2});

    // R7 all drive codes
    for (int c = 0; c < 8; c++) begin
      wr(6'h18, 32'h0070_0000 | 32'(c << 4));
      chk(drive_sel == 3'(c) && drive_legal == (c <= 4), "R7 drive code",
          {28'h0, drive_legal, drive_sel}, {28'h0, c <= 4, 3'(c)});
    end

    // R1 reset in mid-run
    do_reset();
    read_all("R1 after mid-run reset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule